// File: doc/BRIEF.md
# Speculative Line Tracking for a Transactional Cache

This block keeps the speculation state of a local cache in a multiprocessor that runs code as transactions. Each line has a read flag and a modified flag, and each word has a read flag and a renamed flag. The core reports its speculative loads and stores. The block also watches the line addresses that other cores broadcast when they commit.

If another core commits to data this transaction has speculatively read, the block raises a violation. The violation stays raised until the core acknowledges the abort. While it is raised, a mask names every line the transaction modified, so those lines can be discarded.

When the local transaction commits, the block streams the indices of its modified lines, one per cycle and lowest first, so they can be packed into a broadcast. It then clears all tracking state. The line size in words, the number of lines, and whether conflicts are judged per line or per word are parameters. All encodings are plain binary: a line index selects a line, and a word index selects a word within that line.

Top module: `spec_track_bits`

## Requirements
- R1: After reset, `violation` and `cl_valid` are 0 and `discard_mask` is all zeros.
- R2: With `WORD_GRAN`=0, a speculative load marks its line as read. A snooped remote commit to any word of a read line sets `violation` at the clock edge that samples the snoop.
- R3: With `WORD_GRAN`=1, a snooped commit raises `violation` only if it names a line and word that was itself speculatively read. Other words of the same line cause no violation.
- R4: Once raised, `violation` stays 1 until `abort_ack` is sampled. `abort_ack` clears `violation` and every read, modified and renamed flag at that edge.
- R5: While `violation` is 1, bit i of `discard_mask` is 1 exactly when line i was written by a speculative store. While `violation` is 0, the mask is all zeros.
- R6: A speculative store marks its line as modified and its word as renamed. A later load of a renamed word does not mark anything as read.
- R7: A local store to data this transaction read never raises a violation. A snooped commit to a line that was not read raises none.
- R8: A `commit_req` sampled while idle and not violated starts the commit list in the next cycle. `cl_line` gives one modified line index per cycle in ascending order with `cl_valid`=1, and `cl_last` marks the final entry.
- R9: When the commit list ends, all flags are cleared. A `commit_req` with no modified lines produces no `cl_valid` and still clears all flags.
- R10: Loads, stores, snoops and `commit_req` are ignored while violated or while the commit list is being emitted. A snoop hit and a `commit_req` in the same cycle resolve as a violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Speculative load event |
| ld_line | input | LW | Line index of the load |
| ld_word | input | WW | Word index of the load |
| st_valid | input | 1 | Speculative store event |
| st_line | input | LW | Line index of the store |
| st_word | input | WW | Word index of the store |
| snoop_valid | input | 1 | Remote commit address valid |
| snoop_line | input | LW | Line index written by the remote commit |
| snoop_word | input | WW | Word index written by the remote commit |
| commit_req | input | 1 | Local transaction has won commit arbitration |
| abort_ack | input | 1 | Core acknowledges the abort |
| violation | output | 1 | Sticky conflict flag |
| discard_mask | output | NLINES | Modified lines to discard on violation |
| cl_valid | output | 1 | Commit list entry valid |
| cl_line | output | LW | Commit list line index |
| cl_last | output | 1 | Final commit list entry |

## Verification
A read flag wrongly left set shows up as a violation one edge after a snoop to that line. A read flag that should be set but is missing shows up as no violation at that same edge. A wrong modified flag appears immediately in `discard_mask` once violated. It also appears as a missing, extra or out-of-order `cl_line` during the commit list, which the bench observes cycle by cycle. Flags that fail to clear after commit or abort are exposed by a later snoop to a previously read line, which must then stay silent.

// File: rtl/spec_track_bits.sv
module spec_track_bits #(
  parameter int NLINES    = 16,
  parameter int WORDS     = 4,
  parameter bit WORD_GRAN = 1'b0,
  localparam int LW = $clog2(NLINES),
  localparam int WW = $clog2(WORDS),
  localparam int NB = NLINES * WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [LW-1:0]     ld_line,
  input  logic [WW-1:0]     ld_word,
  input  logic              st_valid,
  input  logic [LW-1:0]     st_line,
  input  logic [WW-1:0]     st_word,
  input  logic              snoop_valid,
  input  logic [LW-1:0]     snoop_line,
  input  logic [WW-1:0]     snoop_word,
  input  logic              commit_req,
  input  logic              abort_ack,
  output logic              violation,
  output logic [NLINES-1:0] discard_mask,
  output logic              cl_valid,
  output logic [LW-1:0]     cl_line,
  output logic              cl_last
);

  logic [NB-1:0]     rd, ren;
  logic [NLINES-1:0] mod, mod_rest;
  logic              drain, hit;

  wire active = !violation && !drain;

  generate
    if (WORD_GRAN) begin : g_word
      assign hit = rd[{snoop_line, snoop_word}];
    end else begin : g_line
      assign hit = |rd[snoop_line*WORDS +: WORDS];
    end
  endgenerate

  always_comb begin
    cl_line = '0;
    for (int i = NLINES - 1; i >= 0; i--)
      if (mod[i]) cl_line = LW'(i);
  end

  assign mod_rest     = mod & (mod - 1'b1);
  assign cl_valid     = drain && (mod != '0);
  assign cl_last      = cl_valid && (mod_rest == '0);
  assign discard_mask = violation ? mod : '0;

  always_ff @(posedge clk) begin
    if (!rst_n || abort_ack) begin
      rd <= '0; ren <= '0; mod <= '0;
      violation <= 1'b0; drain <= 1'b0;
    end else if (drain) begin
      if (mod_rest == '0) begin
        rd <= '0; ren <= '0; mod <= '0;
        drain <= 1'b0;
      end else begin
        mod[cl_line] <= 1'b0;
      end
    end else if (active) begin
      if (snoop_valid && hit) violation <= 1'b1;
      else if (commit_req) drain <= 1'b1;
      if (ld_valid && !ren[{ld_line, ld_word}]) rd[{ld_line, ld_word}] <= 1'b1;
      if (st_valid) begin
        mod[st_line] <= 1'b1;
        ren[{st_line, st_word}] <= 1'b1;
      end
    end
  end

  assert_viol_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    violation && !abort_ack |=> violation);

  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ack |=> !violation && !cl_valid && discard_mask == '0);

  assert_ascending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cl_valid && !cl_last && !abort_ack |=> cl_valid && cl_line > $past(cl_line));

  assert_list_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cl_last && !abort_ack |=> !cl_valid);

  assert_no_list_when_violated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    violation |-> !cl_valid);

endmodule

// File: tb/sim_spec_track_bits.sv
module sim_spec_track_bits;
  localparam int CLK_PERIOD = 10;
  localparam int NLINES = 16;
  localparam int WORDS  = 4;
  localparam int LW = $clog2(NLINES);
  localparam int WW = $clog2(WORDS);

  logic clk = 0, rst_n = 0;
  logic ld_valid = 0, st_valid = 0, snoop_valid = 0, commit_req = 0, abort_ack = 0;
  logic [LW-1:0] ld_line = 0, st_line = 0, snoop_line = 0;
  logic [WW-1:0] ld_word = 0, st_word = 0, snoop_word = 0;
  logic violation, cl_valid, cl_last, violation_w, cl_valid_w, cl_last_w;
  logic [NLINES-1:0] discard_mask, discard_mask_w;
  logic [LW-1:0] cl_line, cl_line_w;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spec_track_bits #(.NLINES(NLINES), .WORDS(WORDS), .WORD_GRAN(1'b0)) u0 (
    .clk, .rst_n, .ld_valid, .ld_line, .ld_word, .st_valid, .st_line, .st_word,
    .snoop_valid, .snoop_line, .snoop_word, .commit_req, .abort_ack,
    .violation, .discard_mask, .cl_valid, .cl_line, .cl_last);

  spec_track_bits #(.NLINES(NLINES), .WORDS(WORDS), .WORD_GRAN(1'b1)) u1 (
    .clk, .rst_n, .ld_valid, .ld_line, .ld_word, .st_valid, .st_line, .st_word,
    .snoop_valid, .snoop_line, .snoop_word, .commit_req, .abort_ack,
    .violation(violation_w), .discard_mask(discard_mask_w), .cl_valid(cl_valid_w),
    .cl_line(cl_line_w), .cl_last(cl_last_w));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle_inputs();
    ld_valid = 0; st_valid = 0; snoop_valid = 0; commit_req = 0; abort_ack = 0;
  endtask

  task automatic do_load(input int l, input int w);
    ld_valid = 1; ld_line = LW'(l); ld_word = WW'(w); step(); idle_inputs();
  endtask

  task automatic do_store(input int l, input int w);
    st_valid = 1; st_line = LW'(l); st_word = WW'(w); step(); idle_inputs();
  endtask

  task automatic do_snoop(input int l, input int w);
    snoop_valid = 1; snoop_line = LW'(l); snoop_word = WW'(w); step(); idle_inputs();
  endtask

  task automatic do_ack();
    abort_ack = 1; step(); idle_inputs();
  endtask

  task automatic t_reset();
    rst_n = 0; step(); step(); rst_n = 1;
    check("R1 violation", violation, 0);
    check("R1 cl_valid", cl_valid, 0);
    check("R1 discard_mask", discard_mask, 0);
  endtask

  task automatic t_line_hit();
    do_load(3, 1);
    do_snoop(3, 2);
    check("R2 line-granular hit", violation, 1);
    check("R3 other word no hit", violation_w, 0);
    do_snoop(3, 1);
    check("R3 same word hit", violation_w, 1);
    step();
    check("R4 sticky", violation, 1);
    do_ack();
    check("R4 ack clears violation", violation, 0);
    do_snoop(3, 1);
    check("R4 ack cleared read flags", violation, 0);
  endtask

  task automatic t_rename();
    do_store(4, 0);
    do_load(4, 0);
    do_snoop(4, 0);
    check("R6 renamed word load sets no read", violation, 0);
    do_load(4, 1);
    do_snoop(4, 3);
    check("R6 unrenamed word load sets read", violation, 1);
    do_ack();
  endtask

  task automatic t_war();
    do_load(6, 2);
    do_store(6, 2);
    check("R7 local WAR no violation", violation, 0);
    do_snoop(9, 0);
    check("R7 unread line no violation", violation, 0);
    do_ack();
  endtask

  task automatic t_discard();
    do_store(2, 0);
    do_store(5, 3);
    check("R5 mask zero before violation", discard_mask, 0);
    do_load(8, 0);
    do_snoop(8, 0);
    check("R5 discard mask", discard_mask, 32'h0024);
    do_store(11, 0);
    check("R10 store ignored when violated", discard_mask, 32'h0024);
    commit_req = 1; step(); idle_inputs();
    check("R10 commit ignored when violated", cl_valid, 0);
    do_ack();
    check("R4 ack clears mask", discard_mask, 0);
  endtask

  task automatic t_commit();
    do_store(7, 0);
    do_store(1, 2);
    do_store(12, 3);
    do_load(1, 0);
    commit_req = 1; step(); idle_inputs();
    check("R8 first valid", cl_valid, 1);
    check("R8 first line", cl_line, 1);
    check("R8 first not last", cl_last, 0);
    st_valid = 1; st_line = 0; ld_valid = 1; ld_line = 13; step(); idle_inputs();
    check("R8 second line", cl_line, 7);
    step();
    check("R8 third line", cl_line, 12);
    check("R8 last flagged", cl_last, 1);
    step();
    check("R10 store during list ignored", cl_valid, 0);
    do_snoop(1, 0);
    check("R9 read flags cleared after commit", violation, 0);
    do_snoop(13, 0);
    check("R10 load during list ignored", violation, 0);
  endtask

  task automatic t_empty_commit();
    do_load(10, 1);
    commit_req = 1; step(); idle_inputs();
    check("R9 empty commit no valid", cl_valid, 0);
    step();
    do_snoop(10, 1);
    check("R9 empty commit clears reads", violation, 0);
  endtask

  task automatic t_race();
    do_load(14, 0);
    do_store(15, 0);
    snoop_valid = 1; snoop_line = 14; snoop_word = 0; commit_req = 1; step(); idle_inputs();
    check("R10 snoop wins over commit", violation, 1);
    check("R10 no list on race", cl_valid, 0);
    do_ack();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_line_hit();
    t_rename();
    t_war();
    t_discard();
    t_commit();
    t_empty_commit();
    t_race();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule